// File: doc/BRIEF.md
# Two-Entry Receive Frame Queue with Sticky Overrun

This block sits between the serial bit-recovery logic of an asynchronous receiver and the processor read port. Each time a frame finishes, the recovery logic pulses a frame-complete strobe. With the strobe it presents the data byte, the ninth data bit and a flag saying that the stop bit was missing. The queue keeps up to two such frames. The ninth bit and the framing flag are stored next to the byte they belong to, so software always sees the flags of the oldest stored frame. It should read those flags first and then read the byte, because the read removes that frame and the flags of the next frame take their place.

If a frame completes while both slots are occupied, that frame is thrown away and a sticky overrun flag is raised. The flag then shuts the queue to all new frames, even after reads have made room. The only way to clear it is to drop the receiver enable. Dropping the enable also empties the queue. A data-available flag shows that the queue is not empty, and the interrupt output is that flag gated by an interrupt enable.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset, dataAvail, overrun and irq are all 0.
- R2: When rxEnable is 1, overrun is 0 and a slot is free, a frameValid pulse stores {frameData, frameBit9, frameErr}. From the next cycle on, dataAvail is 1 and, if the queue was empty, headData/headBit9/headErr show that frame.
- R3: When rxEnable is 1, overrun is 0 and both slots are full with no read in the same cycle, a frameValid pulse sets overrun on the next cycle and discards the frame. The stored frames are kept.
- R4: While overrun is 1, frameValid pulses store nothing, even when reads have freed a slot.
- R5: A cycle with rxEnable at 0 clears overrun, empties the queue (dataAvail 0 on the next cycle) and ignores frameValid and readStrobe.
- R6: A readStrobe on a non-empty queue removes the head frame. From the next cycle on, the head outputs show the following frame, so frames leave in arrival order with their own ninth bit and framing flag.
- R7: A readStrobe on an empty queue has no effect.
- R8: A readStrobe and a frameValid in the same cycle with both slots full act as a read followed by a write. Overrun stays 0, the old second frame becomes the head and the new frame is stored behind it.
- R9: dataAvail is 1 exactly when at least one frame is stored, and irq equals dataAvail AND irqEnable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Receiver enable; 0 clears the queue and overrun |
| frameValid | input | 1 | One-cycle pulse: a frame has completed |
| frameData | input | 8 | Received data byte |
| frameBit9 | input | 1 | Received ninth bit |
| frameErr | input | 1 | Framing error (stop bit missing) for this frame |
| readStrobe | input | 1 | Pops the head frame |
| irqEnable | input | 1 | Interrupt enable |
| headData | output | 8 | Data byte of the head frame |
| headBit9 | output | 1 | Ninth bit of the head frame |
| headErr | output | 1 | Framing flag of the head frame |
| dataAvail | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky overrun flag |
| irq | output | 1 | dataAvail AND irqEnable |

## Verification
The bench goes through every sequence of five write/read cycle patterns that starts from an empty queue, and compares against a queue computed in the bench. Several corner cases matter. If a read and a write that land together on a full queue are resolved as write-first, overrun rises and a frame is lost. If the block forgets to hold writes off while overrun is set, a frame appears after a read has freed a slot. If the flags are kept in one shared register instead of travelling with each byte, the head shows the wrong framing bit after a pop. If the block decrements on an empty read, dataAvail stays set or the pointers drift. The sequences also drop rxEnable between runs to check that overrun and the stored frames are cleared.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // strobes from the control to the storage
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } rxq_ctl_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxEnable,
  input  logic             frameValid,
  input  logic             readStrobe,
  output rxq_ctl_t         ctl,
  output logic [CNT_W-1:0] count,
  output logic             overrun
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic             popOk;
  logic [CNT_W-1:0] afterPop;
  logic             setOvr;

  always_comb begin
    popOk     = readStrobe && (count != '0);
    afterPop  = count - CNT_W'(popOk);
    ctl.flush = !rxEnable;
    ctl.pop   = rxEnable && popOk;
    ctl.push  = rxEnable && frameValid && !overrun && (afterPop < FULL);
    setOvr    = rxEnable && frameValid && !overrun && (afterPop == FULL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      overrun <= 1'b0;
    end else if (ctl.flush) begin
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      count <= count + CNT_W'(ctl.push) - CNT_W'(ctl.pop);
      if (setOvr) overrun <= 1'b1;
    end
  end

  // R2: the count never exceeds the depth
  always_comb begin
    if (rstN) a_r2_count_bound: assert (count <= FULL);
  end

  // R3: full, no read, a frame arrives -> overrun next cycle
  a_r3_full_sets_ovr: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && frameValid && !readStrobe && count == FULL) |=> overrun);

  // R4: overrun holds and blocks writes while enabled
  a_r4_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && overrun) |=> overrun);
  a_r4_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && overrun && !readStrobe) |=> $stable(count));

  // R5: disabling clears everything
  a_r5_flush: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (!overrun && count == '0));

  // R8: read and write together on a full queue never overruns
  a_r8_read_first: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && frameValid && readStrobe && !overrun && count == FULL) |=> (!overrun && count == FULL));
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int ENT_W = DATA_W + 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxq_ctl_t         ctl,
  input  logic [ENT_W-1:0] wrEntry,
  output logic [ENT_W-1:0] headEntry
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [ENT_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slot[i] <= '0;
      else if (ctl.push && !ctl.flush && wrPtr == PTR_W'(i)) slot[i] <= wrEntry;
    end
  end

  assign headEntry = slot[rdPtr];

  // R6: a pop with no push advances the read pointer only
  a_r6_pop_moves_head: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pop && !ctl.push && !ctl.flush) |=> (rdPtr != $past(rdPtr) && $stable(wrPtr)));
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              frameValid,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameBit9,
  input  logic              frameErr,
  input  logic              readStrobe,
  input  logic              irqEnable,
  output logic [DATA_W-1:0] headData,
  output logic              headBit9,
  output logic              headErr,
  output logic              dataAvail,
  output logic              overrun,
  output logic              irq
);
  localparam int ENT_W = DATA_W + 2;
  localparam int CNT_W = $clog2(DEPTH + 1);

  rxq_ctl_t         ctl;
  logic [CNT_W-1:0] count;
  logic [ENT_W-1:0] headEntry;

  rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .frameValid(frameValid),
    .readStrobe(readStrobe), .ctl(ctl), .count(count), .overrun(overrun)
  );

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .wrEntry({frameErr, frameBit9, frameData}),
    .headEntry(headEntry)
  );

  assign headData  = headEntry[DATA_W-1:0];
  assign headBit9  = headEntry[DATA_W];
  assign headErr   = headEntry[DATA_W+1];
  assign dataAvail = (count != '0);
  assign irq       = dataAvail && irqEnable;

  // R7: a read on an empty queue with no frame leaves it empty
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && readStrobe && !frameValid && !dataAvail) |=> !dataAvail);

  // R2: a frame accepted into an empty queue makes data available
  a_r2_avail_rise: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnable && frameValid && !overrun && !dataAvail) |=> dataAvail);
endmodule

// File: tb/rx_frame_queue_tb_top.sv
module rx_frame_queue_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b0, frameValid = 1'b0, frameBit9 = 1'b0, frameErr = 1'b0;
  logic readStrobe = 1'b0, irqEnable = 1'b0;
  logic [7:0] frameData = '0;
  logic [7:0] headData;
  logic headBit9, headErr, dataAvail, overrun, irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench-side queue, built from the requirements
  logic [9:0] mq [2];
  int mCount = 0;
  bit mOvr = 1'b0;

  always #10 clk = ~clk;

  rx_frame_queue dut_i (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .frameValid(frameValid),
    .frameData(frameData), .frameBit9(frameBit9), .frameErr(frameErr),
    .readStrobe(readStrobe), .irqEnable(irqEnable), .headData(headData),
    .headBit9(headBit9), .headErr(headErr), .dataAvail(dataAvail),
    .overrun(overrun), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, clock, sample at the next negedge
  task automatic step(input bit en, input bit fv, input bit rd, input bit ie, input logic [7:0] d);
    int prevCount;
    bit prevOvr;
    int after;
    bit popOk;
    logic [9:0] ent;
    string hl;
    string ol;
    rxEnable = en; frameValid = fv; readStrobe = rd; irqEnable = ie;
    frameData = d; frameBit9 = d[0] ^ d[3]; frameErr = d[2];
    ent = {frameErr, frameBit9, d};
    prevCount = mCount; prevOvr = mOvr;
    @(posedge clk);
    @(negedge clk);
    if (!en) begin
      mCount = 0; mOvr = 1'b0;
      chk("R5 avail", int'(dataAvail), 0);
      chk("R5 overrun", int'(overrun), 0);
    end else begin
      popOk = rd && (mCount > 0);
      after = mCount - int'(popOk);
      if (popOk) mq[0] = mq[1];
      mCount = after;
      if (fv && !mOvr) begin
        if (after < 2) begin
          mq[after] = ent;
          mCount = after + 1;
        end else mOvr = 1'b1;
      end
      if (prevCount == 2 && fv && rd && !prevOvr) hl = "R8";
      else if (rd && prevCount == 0) hl = "R7";
      else if (rd) hl = "R6";
      else hl = "R2";
      ol = (prevOvr && fv) ? "R4" : "R3";
      chk("R9 avail", int'(dataAvail), int'(mCount > 0));
      chk("R9 irq", int'(irq), int'((mCount > 0) && ie));
      chk(ol, int'(overrun), int'(mOvr));
      if (mCount > 0) begin
        chk(hl, int'({headErr, headBit9, headData}), int'(mq[0]));
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 avail", int'(dataAvail), 0);
    chk("R1 overrun", int'(overrun), 0);
    chk("R1 irq", int'(irq), 0);
    rstN = 1'b1;
    // sweep every 5-cycle pattern of write/read pairs
    for (int s = 0; s < 1024; s++) begin
      step(1'b0, 1'b1, 1'b1, 1'b1, 8'hA5);
      for (int k = 0; k < 5; k++) begin
        int op;
        op = (s >> (2 * k)) & 3;
        step(1'b1, op[0], op[1], ((s + k) % 3) != 0, 8'((s * 5) + (k * 37) + 1));
      end
    end
    // directed: fill, overrun, read one, write blocked, then clear
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h11);
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h22);
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h33);
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h44);
    chk("R4 blocked head", int'(headData), 'h22);
    step(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    chk("R4 empty after reads", int'(dataAvail), 0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'h55);
    chk("R5 resumes", int'(headData), 'h55);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule